// File: doc/BRIEF.md
# Operand Bypass Select Logic

This block decides where each of the two ALU operands of the instruction in the execute stage comes from. The block serves a five-stage in-order pipeline with a 32-entry register file. It compares both source register numbers with the destination numbers of the two older instructions still in flight. One of those instructions sits just past execute and the other sits just past memory access. For each operand it produces a 2-bit select. The select picks the register-file value, the result one stage ahead, or the result two stages ahead.

A match counts only when the producing instruction writes a register and its destination is not the hardwired-zero register, number 31. When both older instructions write the matching register, the younger result is taken. That younger result sits one stage ahead. This keeps a chain of dependent updates to the same register correct. The compare logic has no state. A small output register stage lets the selects be observed on a clock.

Top module: `bypass_sel_top`

## Requirements
- R1: While reset is held, and after it is released with both write flags low, `sel_a` and `sel_b` read 2'b00.
- R2: When `near_we` is 1, `near_rd` is not 31 and `near_rd` equals an operand's source number, that operand's select is 2'b10.
- R3: When `far_we` is 1, `far_rd` is not 31, `far_rd` equals an operand's source number, and the R2 condition does not hold for that operand, the select is 2'b01.
- R4: When the near and far stages both satisfy their match conditions for the same operand, the select is 2'b10 (the near result wins).
- R5: A destination of 31 never produces a forward, whatever the write flags are. A source number of 31 therefore always yields 2'b00.
- R6: A stage whose write flag is 0 never causes a forward. When neither stage matches, the select is 2'b00.
- R7: The value 2'b11 never appears on either select.
- R8: Operand A depends only on `src_a` and operand B depends only on `src_b`. The two selects are computed independently from the shared stage inputs.
- R9: Each select appears on the ports one clock edge after its inputs are presented. It holds its previous value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| near_rd | input | 5 | Destination number of the instruction one stage ahead |
| near_we | input | 1 | That instruction writes a register |
| far_rd | input | 5 | Destination number of the instruction two stages ahead |
| far_we | input | 1 | That instruction writes a register |
| sel_a | output | 2 | Operand A select: 00 register file, 10 near, 01 far |
| sel_b | output | 2 | Operand B select, same encoding |

## Verification
The hardest case to reach is the double hazard: both stages write, both carry the same destination, that destination is not 31, and it equals a source. Random register numbers rarely line up four ways. The bench instead sweeps every combination of source, near and far numbers drawn from a small set. That set contains 0, 1, a mid value, 30 and 31. The sweep covers all four write-flag pairs, so every double-match and every zero-register case occurs many times. Each vector is also checked just before the clock edge, to confirm the previous select is still held.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    BYP_RF   = 2'b00,
    BYP_FAR  = 2'b01,
    BYP_NEAR = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/stage_hit.sv
module stage_hit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr_en,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  always_comb begin
    hit = wr_en && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/operand_pick.sv
module operand_pick
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] near_rd,
  input  logic             near_we,
  input  logic [REG_W-1:0] far_rd,
  input  logic             far_we,
  output byp_sel_e         sel
);
  logic near_hit;
  logic far_hit;

  stage_hit #(.REG_W(REG_W)) u_near (
    .src(src), .dst(near_rd), .wr_en(near_we), .hit(near_hit)
  );

  stage_hit #(.REG_W(REG_W)) u_far (
    .src(src), .dst(far_rd), .wr_en(far_we), .hit(far_hit)
  );

  // younger producer takes precedence
  always_comb begin
    if (near_hit)     sel = BYP_NEAR;
    else if (far_hit) sel = BYP_FAR;
    else              sel = BYP_RF;
  end
endmodule

// File: rtl/bypass_sel_top.sv
module bypass_sel_top
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] near_rd,
  input  logic             near_we,
  input  logic [REG_W-1:0] far_rd,
  input  logic             far_we,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NUM_OPS = 2;
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [REG_W-1:0] src_arr [NUM_OPS];
  byp_sel_e         sel_d   [NUM_OPS];
  logic [1:0]       sel_q   [NUM_OPS];
  logic             upd_en;

  assign src_arr[0] = src_a;
  assign src_arr[1] = src_b;
  assign upd_en     = 1'b1;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    operand_pick #(.REG_W(REG_W)) u_pick (
      .src(src_arr[g]),
      .near_rd(near_rd), .near_we(near_we),
      .far_rd(far_rd),   .far_we(far_we),
      .sel(sel_d[g])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  sel_q[g] <= 2'b00;
      else if (upd_en)  sel_q[g] <= sel_d[g];
    end

    // R4
    near_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($past(rst_sync_n) && $past(near_we && far_we && near_rd == far_rd &&
        near_rd == src_arr[g] && src_arr[g] != ZERO_REG)) |-> (sel_q[g] == 2'b10));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($past(rst_sync_n) && $past(src_arr[g] == ZERO_REG)) |-> (sel_q[g] == 2'b00));

    // R2
    near_fwd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($past(rst_sync_n) && $past(near_we && near_rd != ZERO_REG &&
        near_rd == src_arr[g])) |-> (sel_q[g] == 2'b10));
  end

  assign sel_a = sel_q[0];
  assign sel_b = sel_q[1];

  // R7
  no_code3_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(!near_we && !far_we)) |-> (sel_a == 2'b00 && sel_b == 2'b00));
endmodule

// File: tb/tb_bypass_sel_top.sv
module tb_bypass_sel_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] src_a, src_b, near_rd, far_rd;
  logic       near_we, far_we;
  logic [1:0] sel_a, sel_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bypass_sel_top dut (
    .clk(clk), .rst_n(rst_n),
    .src_a(src_a), .src_b(src_b),
    .near_rd(near_rd), .near_we(near_we),
    .far_rd(far_rd), .far_we(far_we),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic nwe,
      input logic [4:0] nrd, input logic fwe, input logic [4:0] frd);
    if (nwe && nrd != 5'd31 && nrd == s)      return 2'b10;
    else if (fwe && frd != 5'd31 && frd == s) return 2'b01;
    else                                      return 2'b00;
  endfunction

  function automatic string tag_of(input logic [4:0] s, input logic [1:0] e);
    if (near_we && far_we && near_rd == far_rd && near_rd == s && s != 5'd31) return "R4";
    if (s == 5'd31 || ((near_rd == 5'd31 || far_rd == 5'd31) && e == 2'b00)) return "R5";
    if (e == 2'b10) return "R2";
    if (e == 2'b01) return "R3";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (srcA=%0d srcB=%0d near=%0d/%0b far=%0d/%0b)",
               req, act, exp, src_a, src_b, near_rd, near_we, far_rd, far_we);
    end
  endtask

  initial begin
    logic [4:0] pool [5];
    logic [1:0] prev_a, prev_b, ea, eb;
    pool[0] = 5'd0; pool[1] = 5'd1; pool[2] = 5'd13; pool[3] = 5'd30; pool[4] = 5'd31;
    rst_n = 1'b0;
    src_a = '0; src_b = '0; near_rd = '0; far_rd = '0; near_we = 1'b0; far_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", sel_a, 2'b00);
    check("R1", sel_b, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sel_a, 2'b00);
    check("R1", sel_b, 2'b00);
    prev_a = 2'b00; prev_b = 2'b00;
    for (int w = 0; w < 4; w++)
      for (int ia = 0; ia < 5; ia++)
        for (int ib = 0; ib < 5; ib++)
          for (int in = 0; in < 5; in++)
            for (int jf = 0; jf < 5; jf++) begin
              @(negedge clk);
              src_a = pool[ia]; src_b = pool[ib];
              near_rd = pool[in]; far_rd = pool[jf];
              near_we = w[0]; far_we = w[1];
              ea = ref_sel(src_a, near_we, near_rd, far_we, far_rd);
              eb = ref_sel(src_b, near_we, near_rd, far_we, far_rd);
              #2;
              // R9: old value held before the edge
              check("R9", sel_a, prev_a);
              check("R9", sel_b, prev_b);
              @(posedge clk);
              #1;
              check(tag_of(src_a, ea), sel_a, ea);
              check({"R8 ", tag_of(src_b, eb)}, sel_b, eb);
              n_chk++;
              if (sel_a == 2'b11 || sel_b == 2'b11) begin
                n_fail++;
                $display("FAIL R7: got %b/%b expected not 11", sel_a, sel_b);
              end
              prev_a = ea; prev_b = eb;
            end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule